// File: doc/BRIEF.md
# Circular Trace Capture Controller

This block records a stream of trace frames into an on-chip RAM used as a ring. While capture is enabled, every valid frame passes through a one-entry formatter stage and is then written at the write pointer. The pointer advances and wraps at the end of the RAM, so older frames are overwritten. An external trigger starts a post-trigger countdown. When the countdown runs out, capture freezes and the ring holds the history around the trigger.

Software drives the block through eight 32-bit registers with a one-cycle read latency. Before a run it loads the post-trigger frame count and clears the write pointer, then sets the enable bit. Afterwards it inspects the status flags to locate the oldest frame. It then drains the ring through a data register whose read pointer steps forward on every read.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset the control, write pointer, read pointer and post-trigger count registers read 0 and status reads 0x8. Register addresses are: 0 control, 1 status, 2 depth, 3 frame width, 4 write pointer, 5 read pointer, 6 post-trigger count, 7 RAM data. A read strobe returns its value on `reg_rdata` from the next clock edge on.
- R2: The depth register reads DEPTH (16 by default) and the width register reads FRAME_W (32 by default). Writes to either register have no effect.
- R3: While control bit 0 (enable) is 1 and acquisition is not complete, each cycle with `frame_valid` stores `frame_data` at the write pointer. The pointer then advances modulo DEPTH. Frames offered while enable is 0 are not stored and do not move the pointer.
- R4: Status bit 0 (full) sets when a store moves the write pointer from DEPTH-1 to 0. From then on the write pointer indexes the oldest frame.
- R5: A read of the RAM data register returns the word at the read pointer and then advances the read pointer modulo DEPTH. Writing the read pointer register sets the pointer directly.
- R6: Status bit 1 (triggered) sets when `trig_in` is high while capture is enabled and not complete. A trigger while enable is 0 is ignored.
- R7: With post-trigger count N, exactly N frames are stored starting with the frame of the trigger cycle, and for N=0 that frame is not stored either. Then status bit 2 (acquisition complete) sets, further frames are dropped and the write pointer stays put. The count register reads the remaining count.
- R8: Status bit 3 (formatter empty) is 0 while an accepted frame sits in the formatter stage and not yet in RAM. It returns to 1 once the stage has drained.
- R9: Writing control with bit 0 going from 0 to 1 clears full, triggered and acquisition complete. Writing 0 to control stops capture.
- R10: Control bit 1 (demultiplexed port) is kept only when the port width field, control bits [3:2], holds 1 (8-bit). Field codes are 0 for 4-bit, 1 for 8-bit and 2 for 16-bit. With any other width the bit is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | Trace frame present this cycle |
| frame_data | input | FRAME_W | Trace frame contents |
| trig_in | input | 1 | Trigger event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid from the edge after the strobe |

## Verification
The hardest situation to reach from the ports is the frame pending in the formatter stage, because it lasts for a single cycle. The bench offers a frame and issues a status read in the very next cycle, so the captured status shows formatter empty low, and a later read shows it high again. The post-trigger edges are reached with back-to-back frames around a trigger pulse, for a count of three and for a count of zero, where the trigger-cycle frame itself must be dropped. Wrap-around is covered by writing more frames than the depth and draining from the reported write pointer.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_STATUS = 3'd1,
    REG_DEPTH  = 3'd2,
    REG_WIDTH  = 3'd3,
    REG_WPTR   = 3'd4,
    REG_RPTR   = 3'd5,
    REG_TCOUNT = 3'd6,
    REG_DATA   = 3'd7
  } reg_sel_e;

  localparam logic [1:0] PORT_W8 = 2'b01;

  // pointer step with wrap at an arbitrary depth
  function automatic logic [31:0] wrap_inc(logic [31:0] p, int unsigned depth);
    return (p + 32'd1 >= depth) ? 32'd0 : p + 32'd1;
  endfunction

  // software-loaded pointer, out-of-range values fold to 0
  function automatic logic [31:0] ptr_load(logic [31:0] v, int unsigned depth);
    return (v >= depth) ? 32'd0 : v;
  endfunction

  // demultiplexed mode only accompanies the 8-bit width code
  function automatic logic demux_legal(logic [1:0] width_code);
    return width_code == PORT_W8;
  endfunction
endpackage

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 32,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [FRAME_W-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [FRAME_W-1:0] rdata
);
  logic [FRAME_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trc_fmt_stage.sv
module trc_fmt_stage #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [FRAME_W-1:0] in_data,
  output logic               out_we,
  output logic [FRAME_W-1:0] out_data,
  output logic               empty
);
  logic               hold_v;
  logic [FRAME_W-1:0] hold_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else begin
      hold_v <= in_valid;
      if (in_valid) hold_d <= in_data;
    end
  end

  assign out_we   = hold_v;
  assign out_data = hold_d;
  assign empty    = !hold_v;

  // a frame entering the stage leaves it on the next edge
  assert_stage_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !in_valid) |=> empty);
endmodule

// File: rtl/trc_trig_ctl.sv
module trc_trig_ctl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             en_rise,
  input  logic             frame_valid,
  input  logic             trig_in,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             accept,
  output logic             triggered,
  output logic             acq_done,
  output logic [CNT_W-1:0] count
);
  logic live;       // enabled and not finished
  logic counting;   // trigger seen this cycle or earlier
  logic stop_now;   // count already exhausted at trigger time

  assign live     = en && !acq_done;
  assign counting = live && (trig_in || triggered);
  assign stop_now = counting && (count == '0);
  assign accept   = live && frame_valid && !stop_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      triggered <= 1'b0;
      acq_done  <= 1'b0;
      count     <= '0;
    end else begin
      if (en_rise) begin
        triggered <= 1'b0;
        acq_done  <= 1'b0;
      end else begin
        if (live && trig_in) triggered <= 1'b1;
        if (stop_now || (counting && accept && count == CNT_W'(1)))
          acq_done <= 1'b1;
      end
      if (cnt_wr)
        count <= cnt_wdata;
      else if (counting && accept)
        count <= count - CNT_W'(1);
    end
  end

  assert_no_store_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> !accept);
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_done && !en_rise) |=> acq_done);
  assert_done_needs_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> triggered);
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl #(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               trig_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata
);
  import trc_pkg::*;

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic          ctrl_en, ctrl_demux;
  logic [1:0]    ctrl_width;
  logic [AW-1:0] wptr, rptr;
  logic          full;
  logic [31:0]   rdata_q;

  logic wr_ctrl, wr_wptr, wr_rptr, wr_tcount, rd_data, en_rise;
  assign wr_ctrl   = reg_wr && reg_addr == REG_CTRL;
  assign wr_wptr   = reg_wr && reg_addr == REG_WPTR;
  assign wr_rptr   = reg_wr && reg_addr == REG_RPTR;
  assign wr_tcount = reg_wr && reg_addr == REG_TCOUNT;
  assign rd_data   = reg_rd && reg_addr == REG_DATA;
  assign en_rise   = wr_ctrl && reg_wdata[0] && !ctrl_en;

  // named internal events
  logic               accept, triggered, acq_done, fmt_empty, ram_we, wrap_evt;
  logic [CNT_W-1:0]   tcount;
  logic [FRAME_W-1:0] ram_wdata, ram_rdata;

  trc_trig_ctl #(.CNT_W(CNT_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .en_rise(en_rise),
    .frame_valid(frame_valid), .trig_in(trig_in),
    .cnt_wr(wr_tcount), .cnt_wdata(reg_wdata[CNT_W-1:0]),
    .accept(accept), .triggered(triggered), .acq_done(acq_done), .count(tcount)
  );

  trc_fmt_stage #(.FRAME_W(FRAME_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(accept), .in_data(frame_data),
    .out_we(ram_we), .out_data(ram_wdata), .empty(fmt_empty)
  );

  trc_ram #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wptr), .wdata(ram_wdata),
    .raddr(rptr), .rdata(ram_rdata)
  );

  assign wrap_evt = ram_we && !wr_wptr && (wptr == AW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_demux <= 1'b0;
      ctrl_width <= 2'b00;
      wptr       <= '0;
      rptr       <= '0;
      full       <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en    <= reg_wdata[0];
        ctrl_width <= reg_wdata[3:2];
        ctrl_demux <= reg_wdata[1] && demux_legal(reg_wdata[3:2]);
      end
      if (wr_wptr)     wptr <= AW'(ptr_load(reg_wdata, DEPTH));
      else if (ram_we) wptr <= AW'(wrap_inc(32'(wptr), DEPTH));
      if (wr_rptr)      rptr <= AW'(ptr_load(reg_wdata, DEPTH));
      else if (rd_data) rptr <= AW'(wrap_inc(32'(rptr), DEPTH));
      if (en_rise)       full <= 1'b0;
      else if (wrap_evt) full <= 1'b1;
    end
  end

  logic [31:0] status_word, csr_mux;
  assign status_word = {28'd0, fmt_empty, acq_done, triggered, full};

  always_comb begin
    unique case (reg_addr)
      REG_CTRL:   csr_mux = {28'd0, ctrl_width, ctrl_demux, ctrl_en};
      REG_STATUS: csr_mux = status_word;
      REG_DEPTH:  csr_mux = 32'(DEPTH);
      REG_WIDTH:  csr_mux = 32'(FRAME_W);
      REG_WPTR:   csr_mux = 32'(wptr);
      REG_RPTR:   csr_mux = 32'(rptr);
      REG_TCOUNT: csr_mux = 32'(tcount);
      REG_DATA:   csr_mux = 32'(ram_rdata);
      default:    csr_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= csr_mux;
  end
  assign reg_rdata = rdata_q;

  assert_wptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(wptr) < DEPTH);
  assert_full_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !wr_wptr && !en_rise && wptr == AW'(DEPTH - 1)) |=> (full && wptr == '0));
  assert_frozen_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_done && fmt_empty && !wr_wptr) |=> $stable(wptr));
  assert_rptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !wr_rptr) |=> 32'(rptr) == wrap_inc(32'($past(rptr)), DEPTH));
  assert_demux_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_demux |-> ctrl_width == PORT_W8);
endmodule

// File: tb/trace_capture_ctrl_test.sv
module trace_capture_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [31:0] frame_data = '0;
  logic        trig_in = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  trace_capture_ctrl #(.DEPTH(16), .FRAME_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
    .trig_in(trig_in), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push(logic [31:0] d, logic t);
    frame_valid = 1'b1; frame_data = d; trig_in = t;
    @(negedge clk);
    frame_valid = 1'b0; trig_in = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 status", v, 32'h8);
    rd(3'd4, v); check("R1 wptr", v, 0);
    rd(3'd5, v); check("R1 rptr", v, 0);
    rd(3'd6, v); check("R1 tcount", v, 0);
  endtask

  task automatic t_geometry;
    logic [31:0] v;
    wr(3'd2, 32'd5); wr(3'd3, 32'd7);
    rd(3'd2, v); check("R2 depth", v, 16);
    rd(3'd3, v); check("R2 width", v, 32);
  endtask

  task automatic t_demux;
    logic [31:0] v;
    wr(3'd0, 32'h6); rd(3'd0, v); check("R10 demux with 8-bit", v, 32'h6);
    wr(3'd0, 32'hA); rd(3'd0, v); check("R10 demux with 16-bit", v, 32'h8);
    wr(3'd0, 32'h2); rd(3'd0, v); check("R10 demux with 4-bit", v, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    wr(3'd6, 0); wr(3'd4, 0); wr(3'd0, 1);
    for (int i = 0; i < 5; i++) push(32'hA0 + i, 1'b0);
    idle(2); wr(3'd0, 0);
    rd(3'd4, v); check("R3 wptr after 5", v, 5);
    rd(3'd1, v); check("R3 status", v, 32'h8);
    wr(3'd5, 0);
    for (int i = 0; i < 5; i++) begin
      rd(3'd7, v); check("R5 data", v, 32'hA0 + i);
    end
    rd(3'd5, v); check("R5 rptr advanced", v, 5);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    for (int i = 0; i < 3; i++) push(32'hDEAD, 1'b1);
    idle(2);
    rd(3'd4, v); check("R3 ignored while off", v, 5);
    rd(3'd1, v); check("R6 trigger ignored while off", v, 32'h8);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(3'd4, 0); wr(3'd0, 1);
    for (int i = 0; i < 20; i++) push(32'h100 + i, 1'b0);
    idle(2); wr(3'd0, 0);
    rd(3'd1, v); check("R4 full", v, 32'h9);
    rd(3'd4, v); check("R4 wptr oldest", v, 4);
    wr(3'd5, v);
    for (int i = 0; i < 16; i++) begin
      rd(3'd7, v); check("R4 oldest first", v, 32'h104 + i);
    end
    rd(3'd5, v); check("R5 rptr wrap", v, 4);
  endtask

  task automatic t_trigger;
    logic [31:0] v;
    wr(3'd6, 3); wr(3'd4, 0); wr(3'd0, 1);
    rd(3'd1, v); check("R9 enable clears full", v, 32'h8);
    push(32'hC0, 0); push(32'hC1, 0); push(32'hC2, 1);
    push(32'hC3, 0); push(32'hC4, 0); push(32'hC5, 0); push(32'hC6, 0);
    idle(2);
    rd(3'd4, v); check("R7 three after trigger", v, 5);
    rd(3'd1, v); check("R7 status complete", v, 32'hE);
    rd(3'd6, v); check("R7 count drained", v, 0);
    wr(3'd5, 4); rd(3'd7, v); check("R7 last stored", v, 32'hC4);
    push(32'hC7, 0); idle(2);
    rd(3'd4, v); check("R7 frozen", v, 5);
  endtask

  task automatic t_reenable;
    logic [31:0] v;
    wr(3'd0, 0); wr(3'd6, 8); wr(3'd0, 1);
    rd(3'd1, v); check("R9 flags cleared", v, 32'h8);
    push(32'hE0, 0); idle(2);
    rd(3'd4, v); check("R9 capture resumes", v, 6);
    wr(3'd0, 0); push(32'hE1, 0); idle(2);
    rd(3'd4, v); check("R9 write 0 stops", v, 6);
  endtask

  task automatic t_trig_zero;
    logic [31:0] v;
    wr(3'd6, 0); wr(3'd4, 0); wr(3'd0, 1);
    push(32'hB0, 0); push(32'hB1, 1); push(32'hB2, 0);
    idle(2); wr(3'd0, 0);
    rd(3'd4, v); check("R7 zero count drops trigger frame", v, 1);
    rd(3'd1, v); check("R7 zero count status", v, 32'hE);
    wr(3'd5, 0); rd(3'd7, v); check("R7 zero count data", v, 32'hB0);
  endtask

  task automatic t_fmt_empty;
    logic [31:0] v;
    wr(3'd6, 8); wr(3'd0, 1);
    frame_valid = 1'b1; frame_data = 32'hF0;
    @(negedge clk);
    frame_valid = 1'b0;
    rd(3'd1, v); check("R8 pending frame", v & 32'h8, 0);
    rd(3'd1, v); check("R8 drained", v & 32'h8, 32'h8);
    wr(3'd0, 0);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_geometry();
    t_demux();
    t_basic();
    t_disabled();
    t_wrap();
    t_trigger();
    t_reenable();
    t_trig_zero();
    t_fmt_empty();
    finish_run();
  end
endmodule